// File: doc/BRIEF.md
# Converter Power-Up and Shutdown Sequencer

This block is the control layer between software and an analog-to-digital converter core. Software gives it single-cycle write strobes for an enable bit, a disable bit and a ready-flag clear. The block checks that the supply domain is usable: the deep-power-down signal must be released and the regulator must be on. It also refuses an enable while a calibration is running, and for a short guard window after the calibration finishes. Once an enable is accepted, it raises the analog enable and waits a fixed number of converter clock cycles before it sets a ready flag. That flag can raise an interrupt.

A disable request drops the analog enable and holds the block in a shutdown state until the core acknowledges that it is off. At that point the enable and disable bits both clear together. Conversion-start requests are passed to the datapath only while the converter is ready and no disable is being written. This applies to regular and injected starts, and to both software and trigger sources. All pins are plain control and status levels or pulses, and there is no streaming interface.

Top module: `adc_onoff_ctrl`

## Requirements
- R1: An enable write is ignored unless `pwr_deep_down` is 0 and `vreg_on` is 1 in the same cycle; an ignored write leaves `en_bit` at 0.
- R2: An accepted enable write sets `en_bit` and `ana_enable` one cycle later. `rdy_flag` rises exactly STAB_CYC (default 20) clock edges after the edge that accepted the write.
- R3: A disable write while enabled sets `dis_bit` and drops `ana_enable` on the next edge. `en_bit` and `dis_bit` stay at 1 until `ana_off_ack` is sampled high, and both read 0 one cycle after that sample.
- R4: `rdy_flag` is cleared by a `wr_rdy_clr` strobe. With no strobe it holds its value, and a hardware set in the same cycle as a clear wins.
- R5: `rdy_irq` is high exactly when `rdy_flag` is 1 and `rdy_ie` is 1.
- R6: An enable write is ignored while `cal_busy` is 1. It is also ignored on the first GUARD_CYC (default 4) clock edges that sample `cal_busy` low after it was high. On the next edge it is accepted.
- R7: A regular start pulse `reg_conv_go` is produced one cycle after `sw_reg_start` is sampled, or after `ext_reg_trig` is sampled while `reg_trig_en` is 1. Injected starts behave the same way, using `sw_inj_start`, `ext_inj_trig`, `inj_trig_en` and `inj_conv_go`. The two paths are independent.
- R8: Start requests of either kind are dropped unless the block is ready and no disable write is present in the same cycle. A dropped request is not remembered.
- R9: A disable write while off has no effect. An enable and a disable written in the same cycle resolve to the disable, so from off nothing happens.
- R10: A disable during stabilization aborts the power-up without setting `rdy_flag`. A later enable waits the full STAB_CYC edges again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_deep_down | input | 1 | 1 while the converter is in deep power-down |
| vreg_on | input | 1 | 1 when the converter regulator is enabled |
| cal_busy | input | 1 | 1 while calibration runs |
| wr_en_set | input | 1 | Strobe: software writes 1 to the enable bit |
| wr_dis_set | input | 1 | Strobe: software writes 1 to the disable bit |
| wr_rdy_clr | input | 1 | Strobe: software writes 1 to the ready flag |
| rdy_ie | input | 1 | Ready interrupt enable |
| sw_reg_start | input | 1 | Strobe: software regular start |
| sw_inj_start | input | 1 | Strobe: software injected start |
| ext_reg_trig | input | 1 | External regular trigger event |
| ext_inj_trig | input | 1 | External injected trigger event |
| reg_trig_en | input | 1 | Regular trigger enable |
| inj_trig_en | input | 1 | Injected trigger enable |
| ana_off_ack | input | 1 | Analog core reports it is fully off |
| en_bit | output | 1 | Enable control bit |
| dis_bit | output | 1 | Disable control bit |
| ana_enable | output | 1 | Enable toward the analog core |
| rdy_flag | output | 1 | Ready status flag |
| rdy_irq | output | 1 | Ready interrupt |
| reg_conv_go | output | 1 | One-cycle regular conversion start |
| inj_conv_go | output | 1 | One-cycle injected conversion start |

## Verification
The internal state is never exported, so a wrong state shows up only through the control bits and the gated starts. A stabilization counter that is off by one moves the rise of `rdy_flag` by one edge, which the cycle-exact sampling catches. A state stuck in shutdown keeps `dis_bit` high past the edge after the acknowledge. A wrong guard count lets an enable through one edge too early or holds it off one edge too long. A ready state entered by mistake shows up on the next sampled start request as a spurious `reg_conv_go` or `inj_conv_go`.

// File: rtl/adc_onoff_pkg.sv
package adc_onoff_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_STAB = 2'd1,
    ST_RDY  = 2'd2,
    ST_DIS  = 2'd3
  } onoff_state_e;

  localparam int unsigned NUM_START_PATHS = 2;
  localparam int unsigned PATH_REG = 0;
  localparam int unsigned PATH_INJ = 1;
endpackage

// File: rtl/adc_cal_guard.sv
module adc_cal_guard #(
  parameter int unsigned GUARD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_busy,
  output logic cal_block
);
  localparam int unsigned GW = $clog2(GUARD_CYC + 1);
  localparam logic [GW-1:0] RELOAD = GW'(GUARD_CYC - 1);

  logic          busy_q;
  logic [GW-1:0] left_q;
  logic          fall;

  assign fall      = busy_q & ~cal_busy;
  assign cal_block = cal_busy | fall | (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else begin
      busy_q <= cal_busy;
      if (fall)
        left_q <= RELOAD;
      else if (left_q != '0)
        left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/adc_stab_timer.sv
module adc_stab_timer #(
  parameter int unsigned STAB_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (STAB_CYC > 2) ? $clog2(STAB_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(STAB_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run)
      cnt_q <= '0;
    else if (!done)
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_start_gate.sv
module adc_start_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic allow,
  input  logic sw_start,
  input  logic ext_trig,
  input  logic trig_en,
  output logic go
);
  logic req;

  assign req = sw_start | (trig_en & ext_trig);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      go <= 1'b0;
    else
      go <= allow & req;
  end
endmodule

// File: rtl/adc_onoff_ctrl.sv
module adc_onoff_ctrl
  import adc_onoff_pkg::*;
#(
  parameter int unsigned STAB_CYC  = 20,
  parameter int unsigned GUARD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_deep_down,
  input  logic vreg_on,
  input  logic cal_busy,
  input  logic wr_en_set,
  input  logic wr_dis_set,
  input  logic wr_rdy_clr,
  input  logic rdy_ie,
  input  logic sw_reg_start,
  input  logic sw_inj_start,
  input  logic ext_reg_trig,
  input  logic ext_inj_trig,
  input  logic reg_trig_en,
  input  logic inj_trig_en,
  input  logic ana_off_ack,
  output logic en_bit,
  output logic dis_bit,
  output logic ana_enable,
  output logic rdy_flag,
  output logic rdy_irq,
  output logic reg_conv_go,
  output logic inj_conv_go
);
  onoff_state_e state_q, state_d;
  logic cal_block;
  logic stab_done;
  logic en_ok;
  logic set_rdy;
  logic start_allow;
  logic [NUM_START_PATHS-1:0] sw_vec, ext_vec, ten_vec, go_vec;

  adc_cal_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .cal_busy (cal_busy),
    .cal_block(cal_block)
  );

  adc_stab_timer #(.STAB_CYC(STAB_CYC)) u_stab (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state_q == ST_STAB),
    .done (stab_done)
  );

  // Enable acceptance: power domain usable and no calibration guard.
  assign en_ok = !pwr_deep_down && vreg_on && !cal_block;

  always_comb begin
    state_d = state_q;
    set_rdy = 1'b0;
    unique case (state_q)
      ST_OFF:  if (wr_en_set && !wr_dis_set && en_ok) state_d = ST_STAB;
      ST_STAB: begin
        if (wr_dis_set)     state_d = ST_DIS;
        else if (stab_done) begin
          state_d = ST_RDY;
          set_rdy = 1'b1;
        end
      end
      ST_RDY:  if (wr_dis_set)  state_d = ST_DIS;
      ST_DIS:  if (ana_off_ack) state_d = ST_OFF;
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_OFF;
      en_bit   <= 1'b0;
      dis_bit  <= 1'b0;
      rdy_flag <= 1'b0;
    end else begin
      state_q <= state_d;
      // Control bits follow the state transitions.
      if (state_q == ST_OFF && state_d == ST_STAB)
        en_bit <= 1'b1;
      else if (state_q == ST_DIS && state_d == ST_OFF)
        en_bit <= 1'b0;
      if (state_q != ST_DIS && state_d == ST_DIS)
        dis_bit <= 1'b1;
      else if (state_q == ST_DIS && state_d == ST_OFF)
        dis_bit <= 1'b0;
      // Ready flag: hardware set wins over software clear.
      if (set_rdy)
        rdy_flag <= 1'b1;
      else if (wr_rdy_clr)
        rdy_flag <= 1'b0;
    end
  end

  assign ana_enable = (state_q == ST_STAB) || (state_q == ST_RDY);
  assign rdy_irq    = rdy_flag & rdy_ie;

  // Start gating, shared by regular and injected paths.
  assign start_allow = (state_q == ST_RDY) && !wr_dis_set;

  assign sw_vec[PATH_REG]  = sw_reg_start;
  assign sw_vec[PATH_INJ]  = sw_inj_start;
  assign ext_vec[PATH_REG] = ext_reg_trig;
  assign ext_vec[PATH_INJ] = ext_inj_trig;
  assign ten_vec[PATH_REG] = reg_trig_en;
  assign ten_vec[PATH_INJ] = inj_trig_en;

  for (genvar p = 0; p < NUM_START_PATHS; p++) begin : g_path
    adc_start_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .allow   (start_allow),
      .sw_start(sw_vec[p]),
      .ext_trig(ext_vec[p]),
      .trig_en (ten_vec[p]),
      .go      (go_vec[p])
    );
  end

  assign reg_conv_go = go_vec[PATH_REG];
  assign inj_conv_go = go_vec[PATH_INJ];
endmodule

// File: rtl/adc_onoff_chk.sv
module adc_onoff_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_deep_down,
  input logic vreg_on,
  input logic cal_busy,
  input logic wr_rdy_clr,
  input logic ana_off_ack,
  input logic en_bit,
  input logic dis_bit,
  input logic ana_enable,
  input logic rdy_flag,
  input logic reg_conv_go,
  input logic inj_conv_go
);
  assert_prereq_block_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_bit && (pwr_deep_down || !vreg_on)) |=> !en_bit);

  assert_ana_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ana_enable |-> en_bit);

  assert_dis_drops_ana_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dis_bit |-> !ana_enable);

  assert_dis_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_bit && !ana_off_ack) |=> (dis_bit && en_bit));

  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_bit && ana_off_ack) |=> (!en_bit && !dis_bit));

  assert_rdy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_flag && !wr_rdy_clr) |=> rdy_flag);

  assert_cal_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_bit && cal_busy) |=> !en_bit);

  assert_go_when_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_conv_go || inj_conv_go) |-> (en_bit && !dis_bit));

  assert_dis_off_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_bit && !dis_bit) |=> !dis_bit);
endmodule

bind adc_onoff_ctrl adc_onoff_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwr_deep_down(pwr_deep_down),
  .vreg_on      (vreg_on),
  .cal_busy     (cal_busy),
  .wr_rdy_clr   (wr_rdy_clr),
  .ana_off_ack  (ana_off_ack),
  .en_bit       (en_bit),
  .dis_bit      (dis_bit),
  .ana_enable   (ana_enable),
  .rdy_flag     (rdy_flag),
  .reg_conv_go  (reg_conv_go),
  .inj_conv_go  (inj_conv_go)
);

// File: tb/test_adc_onoff_ctrl.sv
module test_adc_onoff_ctrl;
  localparam int STAB = 20;
  localparam int GUARD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_deep_down = 1'b1, vreg_on = 1'b0, cal_busy = 1'b0;
  logic wr_en_set = 1'b0, wr_dis_set = 1'b0, wr_rdy_clr = 1'b0, rdy_ie = 1'b0;
  logic sw_reg_start = 1'b0, sw_inj_start = 1'b0;
  logic ext_reg_trig = 1'b0, ext_inj_trig = 1'b0;
  logic reg_trig_en = 1'b0, inj_trig_en = 1'b0, ana_off_ack = 1'b0;
  logic en_bit, dis_bit, ana_enable, rdy_flag, rdy_irq, reg_conv_go, inj_conv_go;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  adc_onoff_ctrl #(.STAB_CYC(STAB), .GUARD_CYC(GUARD)) i_adc_onoff_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_deep_down(pwr_deep_down), .vreg_on(vreg_on),
    .cal_busy(cal_busy), .wr_en_set(wr_en_set), .wr_dis_set(wr_dis_set),
    .wr_rdy_clr(wr_rdy_clr), .rdy_ie(rdy_ie), .sw_reg_start(sw_reg_start),
    .sw_inj_start(sw_inj_start), .ext_reg_trig(ext_reg_trig),
    .ext_inj_trig(ext_inj_trig), .reg_trig_en(reg_trig_en),
    .inj_trig_en(inj_trig_en), .ana_off_ack(ana_off_ack), .en_bit(en_bit),
    .dis_bit(dis_bit), .ana_enable(ana_enable), .rdy_flag(rdy_flag),
    .rdy_irq(rdy_irq), .reg_conv_go(reg_conv_go), .inj_conv_go(inj_conv_go)
  );

  // Start table: [8]sw_reg [7]sw_inj [6]ext_reg [5]ext_inj [4]reg_te
  // [3]inj_te [2]dis write [1]expected reg go [0]expected inj go
  localparam logic [8:0] VEC [11] = '{
    9'b1_0_0_0_0_0_0_1_0,
    9'b0_1_0_0_0_0_0_0_1,
    9'b0_0_1_0_0_0_0_0_0,
    9'b0_0_1_0_1_0_0_1_0,
    9'b0_0_0_1_0_0_0_0_0,
    9'b0_0_0_1_0_1_0_0_1,
    9'b0_0_0_1_1_0_0_0_0,
    9'b0_0_0_0_1_1_0_0_0,
    9'b1_0_0_0_0_0_1_0_0,
    9'b1_1_1_1_1_1_0_0_0,
    9'b0_0_0_0_0_0_0_0_0
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic pulse_en();
    wr_en_set = 1'b1; step(); wr_en_set = 1'b0;
  endtask

  task automatic shut_down();
    wr_dis_set = 1'b1; step(); wr_dis_set = 1'b0;
    ana_off_ack = 1'b1; step(); ana_off_ack = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // Reset state
    chk("reset R2 en_bit", en_bit, 1'b0);
    chk("reset R3 dis_bit", dis_bit, 1'b0);
    chk("reset R2 ana_enable", ana_enable, 1'b0);
    chk("reset R4 rdy_flag", rdy_flag, 1'b0);

    // R1: prerequisites
    pwr_deep_down = 1'b1; vreg_on = 1'b1; pulse_en();
    chk("R1 deep-down blocks", en_bit, 1'b0);
    pwr_deep_down = 1'b0; vreg_on = 1'b0; pulse_en();
    chk("R1 regulator off blocks", en_bit, 1'b0);
    vreg_on = 1'b1;

    // R9: disable while off, simultaneous write
    wr_dis_set = 1'b1; step(); wr_dis_set = 1'b0;
    chk("R9 dis in off", dis_bit, 1'b0);
    wr_en_set = 1'b1; wr_dis_set = 1'b1; step();
    wr_en_set = 1'b0; wr_dis_set = 1'b0;
    chk("R9 both en", en_bit, 1'b0);
    chk("R9 both dis", dis_bit, 1'b0);

    // R6: calibration and guard window
    cal_busy = 1'b1; step();
    pulse_en();
    chk("R6 cal busy blocks", en_bit, 1'b0);
    cal_busy = 1'b0; wr_en_set = 1'b1;
    for (int i = 0; i < GUARD; i++) begin
      step();
      chk("R6 guard window", en_bit, 1'b0);
    end
    step(); wr_en_set = 1'b0;
    chk("R6 accepted after guard", en_bit, 1'b1);
    chk("R2 ana_enable on", ana_enable, 1'b1);

    // R2: stabilization timing; R8 starts ignored while stabilizing
    sw_reg_start = 1'b1;
    for (int i = 1; i <= STAB; i++) begin
      step();
      if (i == 1) begin
        sw_reg_start = 1'b0;
        chk("R8 start while stabilizing", reg_conv_go, 1'b0);
      end
      chk("R2 ready timing", rdy_flag, (i == STAB));
    end

    // R5 interrupt
    chk("R5 irq masked", rdy_irq, 1'b0);
    rdy_ie = 1'b1; #1;
    chk("R5 irq raised", rdy_irq, 1'b1);

    // R4 write-one-to-clear
    step();
    chk("R4 hold without write", rdy_flag, 1'b1);
    wr_rdy_clr = 1'b1; step(); wr_rdy_clr = 1'b0;
    chk("R4 cleared", rdy_flag, 1'b0);
    chk("R5 irq follows clear", rdy_irq, 1'b0);

    // R7/R8 table walk in ready state, ending with a disable
    foreach (VEC[k]) begin
      {sw_reg_start, sw_inj_start, ext_reg_trig, ext_inj_trig,
       reg_trig_en, inj_trig_en, wr_dis_set} = VEC[k][8:2];
      step();
      {sw_reg_start, sw_inj_start, ext_reg_trig, ext_inj_trig,
       reg_trig_en, inj_trig_en, wr_dis_set} = '0;
      chk("R7 R8 regular go", reg_conv_go, VEC[k][1]);
      chk("R7 R8 injected go", inj_conv_go, VEC[k][0]);
    end

    // R3 shutdown handshake
    chk("R3 dis_bit set", dis_bit, 1'b1);
    chk("R3 en_bit held", en_bit, 1'b1);
    chk("R3 ana_enable dropped", ana_enable, 1'b0);
    repeat (3) step();
    chk("R3 waits for ack", dis_bit, 1'b1);
    ana_off_ack = 1'b1; step(); ana_off_ack = 1'b0;
    chk("R3 en cleared by ack", en_bit, 1'b0);
    chk("R3 dis cleared by ack", dis_bit, 1'b0);

    // R10 abort during stabilization, then full restart
    pulse_en();
    repeat (STAB - 3) step();
    shut_down();
    chk("R10 aborted no ready", rdy_flag, 1'b0);
    chk("R10 back off", en_bit, 1'b0);
    pulse_en();
    for (int i = 1; i <= STAB; i++) begin
      step();
      chk("R10 full interval again", rdy_flag, (i == STAB));
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule